// File: doc/BRIEF.md
# Two-wire bus start/stop condition detector

This block watches the clock line and the data line of an I2C-style two-wire bus. It reports two kinds of event. A start is a falling data line while the clock line is high. A stop is a rising data line while the clock line is high. Both lines first pass through a two-flop synchroniser. They are then sampled on a tick. The tick fires on every base clock, or on every second base clock when the slow select is high.

An event is accepted only when two windows are met. The clock line must have been high for at least `WIN` ticks before the data edge. After the edge, the clock line must stay high and the data line must keep its new level for `WIN` more ticks. This rejects short glitches on either line.

Each accepted event does three things:
- It produces a one-cycle pulse on its own output.
- It updates a bus-busy flag.
- It raises one interrupt request that is shared by both kinds.

Software reads the busy flag to learn which kind of event caused the interrupt. It then clears the request with an acknowledge input.

Top module: `twowire_cond_watch`

## Requirements
- R1: A data fall with the clock line high, with both windows met, gives exactly one one-cycle pulse on `start_o` and none on `stop_o`.
- R2: A data rise with the clock line high, with both windows met, gives exactly one one-cycle pulse on `stop_o` and none on `start_o`.
- R3: `bus_busy_o` resets to 0. It becomes 1 with a start pulse, becomes 0 with a stop pulse, and holds its value otherwise.
- R4: `irq_o` resets to 0 and is set by either event. It stays set until a cycle with `irq_ack_i`=1 clears it. An event in the same cycle as the acknowledge wins and leaves `irq_o`=1 for that cycle.
- R5: If the clock line was high for fewer than `WIN` ticks before the data edge, no event is produced.
- R6: If the clock line falls before `WIN` ticks have passed after the data edge, no event is produced.
- R7: With `slow_sel_i`=1, a tick occurs only every second base clock, so both windows last twice as many base clocks.
- R8: Data line changes while the clock line is low produce no event and leave `bus_busy_o` unchanged.
- R9: A data line pulse that returns to its old level before the hold window ends produces no event. This holds even though its trailing edge also happens with the clock line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line |
| slow_sel_i | input | 1 | 1: tick every second base clock; 0: tick every base clock |
| irq_ack_i | input | 1 | Clears the pending interrupt request |
| irq_o | output | 1 | Shared start/stop interrupt request |
| bus_busy_o | output | 1 | 1 after a start, 0 after a stop |
| start_o | output | 1 | One-cycle start pulse |
| stop_o | output | 1 | One-cycle stop pulse |

## Verification
The bench builds the block with `WIN`=4.

At full rate this places the boundaries one tick apart:
- Setup: three high ticks before the edge are rejected, and four are accepted.
- Hold: a clock line that falls four base clocks after the data edge is rejected, and one that falls five clocks after is accepted.

At half rate, the same four-clock setup that passes at full rate covers only two ticks and must be rejected. This makes the rate select observable.

// File: rtl/twowire_cond_watch.sv
module twowire_cond_watch #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic slow_sel_i,
  input  logic irq_ack_i,
  output logic irq_o,
  output logic bus_busy_o,
  output logic start_o,
  output logic stop_o
);
  localparam logic [2:0] WIN_Q   = 3'(WIN);
  localparam logic [2:0] RUN_MAX = 3'd7;

  typedef enum logic {S_IDLE, S_HOLD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_now, sda_now;
  logic       phase, tick, sda_q;
  logic [2:0] run, hcnt;
  st_t        st;
  logic       kind;
  logic       edge_ok, hold_ok, done;

  assign scl_now = scl_sy[1];
  assign sda_now = sda_sy[1];
  assign tick    = slow_sel_i ? phase : 1'b1;

  assign edge_ok = (st == S_IDLE) && tick && scl_now && (sda_now != sda_q) && (run >= WIN_Q);
  assign hold_ok = (st == S_HOLD) && tick && scl_now && (sda_now == ~kind);
  assign done    = hold_ok && (hcnt == WIN_Q - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      phase  <= 1'b0;
      sda_q  <= 1'b1;
      run    <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      phase  <= ~phase;
      if (tick) begin
        sda_q <= sda_now;
        if (!scl_now)            run <= '0;
        else if (run != RUN_MAX) run <= run + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
      kind <= 1'b0;
    end else if (edge_ok) begin
      st   <= S_HOLD;
      hcnt <= '0;
      kind <= ~sda_now;
    end else if (st == S_HOLD && tick) begin
      if (!hold_ok || done) st <= S_IDLE;
      else                  hcnt <= hcnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      bus_busy_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      start_o <= done & kind;
      stop_o  <= done & ~kind;
      if (done) bus_busy_o <= kind;
      irq_o <= done | (irq_o & ~irq_ack_i);
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n) !(start_o && stop_o));
  p_start_once_r1: assert property (@(posedge clk) disable iff (!rst_n) start_o |=> !start_o);
  p_stop_once_r2: assert property (@(posedge clk) disable iff (!rst_n) stop_o |=> !stop_o);
  p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n) start_o |-> bus_busy_o);
  p_busy_clr_r3: assert property (@(posedge clk) disable iff (!rst_n) stop_o |-> !bus_busy_o);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_o && !stop_o) |-> $stable(bus_busy_o));
  p_irq_set_r4: assert property (@(posedge clk) disable iff (!rst_n) (start_o || stop_o) |-> irq_o);
  p_irq_keep_r4: assert property (@(posedge clk) disable iff (!rst_n) (irq_o && !irq_ack_i) |=> irq_o);
  p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_o) |-> $past(irq_ack_i));
  p_tick_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel_i && tick) |=> (!tick || !slow_sel_i));
endmodule

// File: tb/twowire_cond_watch_bench.sv
module twowire_cond_watch_bench;
  localparam int W  = 4;
  localparam int NV = 8;
  // [12] start(1)/stop(0), [11] slow, [10:6] setup clocks, [5:1] hold clocks, [0] event expected
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd4,  5'd5,  1'b1},  // R1
    {1'b0, 1'b0, 5'd4,  5'd5,  1'b1},  // R2
    {1'b1, 1'b0, 5'd3,  5'd5,  1'b0},  // R5
    {1'b0, 1'b0, 5'd4,  5'd4,  1'b0},  // R6
    {1'b1, 1'b1, 5'd10, 5'd11, 1'b1},  // R7
    {1'b1, 1'b1, 5'd4,  5'd11, 1'b0},  // R7
    {1'b0, 1'b1, 5'd10, 5'd11, 1'b1},  // R7
    {1'b0, 1'b0, 5'd3,  5'd9,  1'b0}   // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, slow = 1'b0, ack = 1'b0;
  logic irq, busy, st_p, sp_p;
  int n_start = 0, n_stop = 0, n_irq = 0;
  int checks = 0, fails = 0;
  bit model_busy = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twowire_cond_watch #(.WIN(W)) u_twowire_cond_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .slow_sel_i(slow),
    .irq_ack_i(ack), .irq_o(irq), .bus_busy_o(busy), .start_o(st_p), .stop_o(sp_p));

  always @(negedge clk) if (rst_n) begin
    if (st_p) n_start++;
    if (sp_p) n_stop++;
    if (irq)  n_irq++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scenario(input bit is_start, input bit sl, input int su, input int hd,
                          input bit hold_ack, output int ds, output int dp, output int di);
    int s0, p0, i0;
    slow = sl;
    ack  = hold_ack;
    scl  = 1'b0;
    wait_clk(2);
    sda = is_start;
    wait_clk(20);
    s0 = n_start; p0 = n_stop; i0 = n_irq;
    scl = 1'b1;
    wait_clk(su);
    sda = ~is_start;
    wait_clk(hd);
    scl = 1'b0;
    wait_clk(20);
    ds = n_start - s0; dp = n_stop - p0; di = n_irq - i0;
  endtask

  task automatic clear_irq();
    ack = 1'b1;
    wait_clk(1);
    ack = 1'b0;
    wait_clk(1);
  endtask

  initial begin
    wait_clk(400000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ds, dp, di, s0, p0;
    wait_clk(3);
    chk(irq == 1'b0 && busy == 1'b0, "R3 reset state", {30'd0, irq, busy}, 0);
    chk(st_p == 1'b0 && sp_p == 1'b0, "R1 reset pulses", {30'd0, st_p, sp_p}, 0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      bit exp_ev;
      v = VEC[i];
      exp_ev = v[0];
      scenario(v[12], v[11], int'(v[10:6]), int'(v[5:1]), 1'b0, ds, dp, di);
      chk(ds == ((exp_ev && v[12]) ? 1 : 0), "R1/R5/R6/R7 start count", ds, (exp_ev && v[12]) ? 1 : 0);
      chk(dp == ((exp_ev && !v[12]) ? 1 : 0), "R2/R5/R6/R7 stop count", dp, (exp_ev && !v[12]) ? 1 : 0);
      if (exp_ev) model_busy = v[12];
      chk(busy == model_busy, "R3 busy after vector", int'(busy), int'(model_busy));
      chk(irq == exp_ev, "R4 irq after vector", int'(irq), int'(exp_ev));
      clear_irq();
      chk(irq == 1'b0, "R4 irq after ack", int'(irq), 0);
    end

    // R4: acknowledge held high across the event; the event wins for one cycle
    scenario(1'b1, 1'b0, 4, 5, 1'b1, ds, dp, di);
    ack = 1'b0;
    chk(ds == 1, "R4 start with ack held", ds, 1);
    chk(di == 1, "R4 irq high cycles with ack held", di, 1);
    chk(irq == 1'b0, "R4 irq cleared by held ack", int'(irq), 0);
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);

    // R4: request stays pending until acknowledged
    scenario(1'b0, 1'b0, 6, 8, 1'b0, ds, dp, di);
    wait_clk(15);
    chk(irq == 1'b1, "R4 irq pending without ack", int'(irq), 1);
    chk(busy == 1'b0, "R3 busy after stop", int'(busy), 0);
    clear_irq();
    chk(irq == 1'b0, "R4 irq cleared", int'(irq), 0);

    // R8: data toggling with the clock line low
    slow = 1'b0;
    scl = 1'b0;
    wait_clk(5);
    s0 = n_start; p0 = n_stop;
    for (int k = 0; k < 6; k++) begin
      sda = ~sda;
      wait_clk(3);
    end
    wait_clk(10);
    chk(n_start == s0 && n_stop == p0, "R8 no event with clock low", n_start + n_stop - s0 - p0, 0);
    chk(busy == 1'b0 && irq == 1'b0, "R8 state unchanged", {30'd0, busy, irq}, 0);

    // R9: short data pulse with the clock line high
    sda = 1'b1;
    wait_clk(3);
    scl = 1'b1;
    wait_clk(10);
    s0 = n_start; p0 = n_stop;
    sda = 1'b0;
    wait_clk(2);
    sda = 1'b1;
    wait_clk(15);
    chk(n_start == s0 && n_stop == p0, "R9 glitch rejected", n_start + n_stop - s0 - p0, 0);
    chk(busy == 1'b0 && irq == 1'b0, "R9 state unchanged", {30'd0, busy, irq}, 0);
    scl = 1'b0;
    wait_clk(5);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule